// File: doc/BRIEF.md
# Port Error Interrupt Controller with Clock-Activity Monitors

This block gathers error events from the surrounding port logic into a sticky status register. The events are a dropped ingress transfer on the fast port, a dropped ingress transfer on the slow port, a stalled ingress clock, a stalled egress clock, and a buffer flush. Software reads the status word and writes ones to the bits it has handled, which clears them. A companion enable word chooses which status bits may raise the interrupt line.

A second register holds the most recent 6-bit event-type code reported by a channel. It has its own enable mask. Writing 0xFF to its low byte clears it. Two built-in activity monitors synchronise a monitored clock into the reference clock domain. Each monitor counts reference cycles that pass without a toggle and reports a stall once, when the count reaches a parameter. The single interrupt output is registered.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_o` is 0.
- R2: A pulse on the matching input sets a port status bit at offset 0x0C, and the bit stays set. The bits are: bit 0 for a fast-port drop, bit 1 for a slow-port drop, bit 2 for an ingress clock stall, bit 3 for an egress clock stall, and bit 4 for a flush.
- R3: A write to 0x0C clears each status bit whose data bit is 1. A status bit whose data bit is 0 keeps its value.
- R4: If a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Offset 0x0D is a read/write enable word for status bits 4:0. In both 0x0C and 0x0D, bits 31:5 read as 0.
- R6: A clock monitor sets its status bit once the monitored clock has shown no toggle for `MISS_LIMIT` reference cycles (plus the synchroniser delay). It reports a stall only once until the clock toggles again, and after a recovery it can report again.
- R7: Offset 0x0E holds a 6-bit event-type code in bits 5:0, and bits 31:6 read as 0. `evt_valid_i` loads `evt_code_i` into it. A write whose low byte is 0xFF clears it. Any other write has no effect. A load in the same cycle as a clear wins.
- R8: Offset 0x0F is a read/write 6-bit enable word for the event-type code. Bits 31:6 read as 0.
- R9: `irq_o` equals, one cycle later, the OR of (status AND enable) together with the OR of (event code AND event enable).
- R10: A flush caused by an address parity error (`flush_parity_i`) and a flush caused by a missing buffer (`flush_nobuf_i`) both set status bit 4.
- R11: Offsets other than 0x0C to 0x0F read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| hs_drop_i | input | 1 | Fast-port ingress drop pulse |
| ls_drop_i | input | 1 | Slow-port ingress drop pulse |
| flush_parity_i | input | 1 | Flush pulse caused by an address parity error |
| flush_nobuf_i | input | 1 | Flush pulse caused by no free ingress buffer |
| ing_clk_mon_i | input | 1 | Monitored ingress clock |
| egr_clk_mon_i | input | 1 | Monitored egress clock |
| evt_valid_i | input | 1 | Event-type code valid |
| evt_code_i | input | 6 | Event-type code |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A status bit that is wrongly stuck or wrongly lost shows up on the very next read of 0x0C. If that bit is enabled, it also shows up on `irq_o` one cycle after the faulty edge. An enable or event register that holds the wrong value shows up both in its read value and in the interrupt line in the following cycle. A monitor counter that runs too fast, too slow, or repeats its report shows up as a stall bit that appears early, appears late, or comes back after being cleared while the clock stays dead. The bench catches each of these within a window of a few cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_AW    = 8;
    localparam int REG_DW    = 32;
    localparam int PORT_BITS = 5;
    localparam int EVT_W     = 6;

    localparam logic [REG_AW-1:0] OFF_PORT_ST = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_PORT_EN = 8'h0D;
    localparam logic [REG_AW-1:0] OFF_EVT     = 8'h0E;
    localparam logic [REG_AW-1:0] OFF_EVT_EN  = 8'h0F;
    localparam logic [7:0]        EVT_ACK     = 8'hFF;

    // packed order gives flush at bit 4 and hs_drop at bit 0
    typedef struct packed {
        logic flush;
        logic egr_clk;
        logic ing_clk;
        logic ls_drop;
        logic hs_drop;
    } port_evt_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_PORT_ST, SEL_PORT_EN, SEL_EVT, SEL_EVT_EN
    } reg_sel_e;

    function automatic reg_sel_e decode(logic [REG_AW-1:0] a);
        case (a)
            OFF_PORT_ST: return SEL_PORT_ST;
            OFF_PORT_EN: return SEL_PORT_EN;
            OFF_EVT:     return SEL_EVT;
            OFF_EVT_EN:  return SEL_EVT_EN;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [REG_DW-1:0] zext_port(logic [PORT_BITS-1:0] v);
        return {{(REG_DW-PORT_BITS){1'b0}}, v};
    endfunction

    function automatic logic [REG_DW-1:0] zext_evt(logic [EVT_W-1:0] v);
        return {{(REG_DW-EVT_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/irq_clk_monitor.sv
module irq_clk_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int MISS_LIMIT  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_clk_i,
    output logic fail_o
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(MISS_LIMIT);
    localparam logic [CW-1:0] TRIP_C  = CW'(MISS_LIMIT - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [CW-1:0]          cnt_q;
    logic                   toggle;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= mon_clk_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign toggle = sync_q[SYNC_STAGES-1] ^ last_q;
    assign fail_o = !toggle && (cnt_q == TRIP_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
            if (toggle)                cnt_q <= '0;
            else if (cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q_o[b] <= 1'b0;
            else if (set_i[b]) q_o[b] <= 1'b1;
            else if (clr_i[b]) q_o[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MISS_LIMIT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic              hs_drop_i,
    input  logic              ls_drop_i,
    input  logic              flush_parity_i,
    input  logic              flush_nobuf_i,
    input  logic              ing_clk_mon_i,
    input  logic              egr_clk_mon_i,
    input  logic              evt_valid_i,
    input  logic [EVT_W-1:0]  evt_code_i,
    output logic              irq_o
);
    reg_sel_e              sel;
    port_evt_t             set_s;
    logic [PORT_BITS-1:0]  port_clr;
    logic [PORT_BITS-1:0]  port_st;
    logic [PORT_BITS-1:0]  port_en_q;
    logic [EVT_W-1:0]      evt_q;
    logic [EVT_W-1:0]      evt_en_q;
    logic                  ing_fail;
    logic                  egr_fail;
    logic                  evt_ack;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[REG_DW-1:8];
    assign sel = decode(reg_addr_i);

    irq_clk_monitor #(.SYNC_STAGES(SYNC_STAGES), .MISS_LIMIT(MISS_LIMIT)) u_ing_mon (
        .clk(clk), .rst(rst), .mon_clk_i(ing_clk_mon_i), .fail_o(ing_fail)
    );
    irq_clk_monitor #(.SYNC_STAGES(SYNC_STAGES), .MISS_LIMIT(MISS_LIMIT)) u_egr_mon (
        .clk(clk), .rst(rst), .mon_clk_i(egr_clk_mon_i), .fail_o(egr_fail)
    );

    always_comb begin
        set_s.hs_drop = hs_drop_i;
        set_s.ls_drop = ls_drop_i;
        set_s.ing_clk = ing_fail;
        set_s.egr_clk = egr_fail;
        set_s.flush   = flush_parity_i | flush_nobuf_i;
    end

    assign port_clr = (reg_wr_i && sel == SEL_PORT_ST) ? reg_wdata_i[PORT_BITS-1:0] : '0;
    assign evt_ack  = reg_wr_i && (sel == SEL_EVT) && (reg_wdata_i[7:0] == EVT_ACK);

    irq_sticky_bank #(.W(PORT_BITS)) u_port_st (
        .clk(clk), .rst(rst), .set_i(set_s), .clr_i(port_clr), .q_o(port_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            port_en_q <= '0;
            evt_q     <= '0;
            evt_en_q  <= '0;
            irq_o     <= 1'b0;
        end else begin
            if (reg_wr_i && sel == SEL_PORT_EN) port_en_q <= reg_wdata_i[PORT_BITS-1:0];
            if (reg_wr_i && sel == SEL_EVT_EN)  evt_en_q  <= reg_wdata_i[EVT_W-1:0];
            if (evt_valid_i)  evt_q <= evt_code_i;
            else if (evt_ack) evt_q <= '0;
            irq_o <= (|(port_st & port_en_q)) | (|(evt_q & evt_en_q));
        end
    end

    always_comb begin
        case (sel)
            SEL_PORT_ST: reg_rdata_o = zext_port(port_st);
            SEL_PORT_EN: reg_rdata_o = zext_port(port_en_q);
            SEL_EVT:     reg_rdata_o = zext_evt(evt_q);
            SEL_EVT_EN:  reg_rdata_o = zext_evt(evt_en_q);
            default:     reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
    import irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [REG_DW-1:0]    reg_wdata,
    input logic [REG_DW-1:0]    reg_rdata,
    input logic                 irq,
    input logic [PORT_BITS-1:0] port_set,
    input logic [PORT_BITS-1:0] port_st,
    input logic [PORT_BITS-1:0] port_en,
    input logic [EVT_W-1:0]     evt,
    input logic [EVT_W-1:0]     evt_en,
    input logic                 evt_valid,
    input logic                 ing_fail,
    input logic                 egr_fail
);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (port_set != '0) |=> ((port_st & $past(port_set)) == $past(port_set)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_PORT_ST) |=>
            ((port_st & $past(reg_wdata[PORT_BITS-1:0] & ~port_set)) == '0));

    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == OFF_PORT_ST) |=> ((port_st & $past(port_st)) == $past(port_st)));

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == ($past(|(port_st & port_en)) || $past(|(evt & evt_en)))));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_PORT_ST || reg_addr == OFF_PORT_EN) |-> (reg_rdata[REG_DW-1:PORT_BITS] == '0));

    assert_evt_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_EVT && reg_wdata[7:0] == EVT_ACK && !evt_valid) |=> (evt == '0));

    assert_ing_once_R6: assert property (@(posedge clk) disable iff (rst)
        ing_fail |=> !ing_fail);

    assert_egr_once_R6: assert property (@(posedge clk) disable iff (rst)
        egr_fail |=> !egr_fail);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr_i), .reg_addr(reg_addr_i),
    .reg_wdata(reg_wdata_i), .reg_rdata(reg_rdata_o), .irq(irq_o),
    .port_set(set_s), .port_st(port_st), .port_en(port_en_q),
    .evt(evt_q), .evt_en(evt_en_q), .evt_valid(evt_valid_i),
    .ing_fail(ing_fail), .egr_fail(egr_fail)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
    localparam int MISS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hs = 0, ls = 0, fpar = 0, fnob = 0, ev = 0;
    logic [5:0]  code = '0;
    logic        ing_clk = 0, egr_clk = 0, ing_run = 1, egr_run = 1;
    logic        irq;

    int tests = 0, fails = 0;
    logic [4:0] m_st = '0, m_en = '0;
    logic [5:0] m_evt = '0, m_evten = '0;
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) begin
        if (ing_run) ing_clk = ~ing_clk;
        if (egr_run) egr_clk = ~egr_clk;
    end

    irq_status_ctrl #(.SYNC_STAGES(2), .MISS_LIMIT(MISS)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .hs_drop_i(hs), .ls_drop_i(ls), .flush_parity_i(fpar), .flush_nobuf_i(fnob),
        .ing_clk_mon_i(ing_clk), .egr_clk_mon_i(egr_clk),
        .evt_valid_i(ev), .evt_code_i(code), .irq_o(irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h0C:   return {27'b0, m_st};
            8'h0D:   return {27'b0, m_en};
            8'h0E:   return {26'b0, m_evt};
            8'h0F:   return {26'b0, m_evten};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one clock with the given stimulus; the bench model steps with it
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic h, input logic l, input logic fp, input logic fn,
                       input logic e, input logic [5:0] c);
        logic       nirq;
        logic [4:0] setv, clrv;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        hs = h; ls = l; fpar = fp; fnob = fn; ev = e; code = c;
        @(posedge clk);
        nirq = (|(m_st & m_en)) | (|(m_evt & m_evten));
        setv = {fp | fn, 1'b0, 1'b0, l, h};
        clrv = (wr && a == 8'h0C) ? d[4:0] : 5'h0;
        m_st = (m_st & ~clrv) | setv;
        if (wr && a == 8'h0D) m_en = d[4:0];
        if (e) m_evt = c;
        else if (wr && a == 8'h0E && d[7:0] == 8'hFF) m_evt = '0;
        if (wr && a == 8'h0F) m_evten = d[5:0];
        m_irq = nirq;
        #1;
        reg_wr = 0; hs = 0; ls = 0; fpar = 0; fnob = 0; ev = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 6'h0);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0, 0, 0, 0, 6'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        rd_chk("R1 status", 8'h0C); rd_chk("R1 enable", 8'h0D);
        rd_chk("R1 evt", 8'h0E);    rd_chk("R1 evt_en", 8'h0F);
        check("R1 irq", {31'b0, irq}, 32'h0);
        idle(4);
        rd_chk("R1 status idle with clocks running", 8'h0C);

        // R6 ingress monitor: quiet, then stall, then once, then re-arm
        ing_run = 0;
        idle(MISS - 4);
        rd_chk("R6 no early stall", 8'h0C);
        idle(10);
        m_st[2] = 1'b1;
        rd_chk("R6 ingress stall sets bit2", 8'h0C);
        wr_reg(8'h0C, 32'h4);
        idle(MISS + 6);
        rd_chk("R6 stall reported once", 8'h0C);
        ing_run = 1; idle(5); ing_run = 0;
        idle(MISS + 6);
        m_st[2] = 1'b1;
        rd_chk("R6 stall after recovery", 8'h0C);
        ing_run = 1;
        egr_run = 0;
        idle(MISS + 6);
        m_st[3] = 1'b1;
        rd_chk("R6 egress stall sets bit3", 8'h0C);
        egr_run = 1; idle(4);
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R3 write ones clears all", 8'h0C);

        // R2 / R10 sources
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); rd_chk("R2 fast drop bit0", 8'h0C);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); rd_chk("R2 slow drop bit1", 8'h0C);
        wr_reg(8'h0C, 32'h1F);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); rd_chk("R10 parity flush bit4", 8'h0C);
        wr_reg(8'h0C, 32'h10);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); rd_chk("R10 nobuf flush bit4", 8'h0C);
        // R3 zeros leave bits, R4 set wins
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
        wr_reg(8'h0C, 32'h2);
        rd_chk("R3 zero bits unchanged", 8'h0C);
        cyc(1, 8'h0C, 32'h1, 1, 0, 0, 0, 0, 0);
        rd_chk("R4 set beats clear", 8'h0C);

        // R5 / R8 enables, reserved bits
        wr_reg(8'h0D, 32'hFFFF_FFE5); rd_chk("R5 enable rw", 8'h0D);
        wr_reg(8'h0F, 32'hFFFF_FFEA); rd_chk("R8 evt enable rw", 8'h0F);
        // R9 interrupt
        idle(1);
        check("R9 irq from enabled status", {31'b0, irq}, {31'b0, m_irq});
        wr_reg(8'h0C, 32'h1F); wr_reg(8'h0D, 32'h0); idle(2);
        check("R9 irq low when cleared", {31'b0, irq}, {31'b0, m_irq});

        // R7 event type
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h2A); rd_chk("R7 code load", 8'h0E);
        idle(2);
        check("R9 irq from event code", {31'b0, irq}, {31'b0, m_irq});
        wr_reg(8'h0E, 32'h0000_00FE); rd_chk("R7 non-FF write ignored", 8'h0E);
        cyc(1, 8'h0E, 32'hFF, 0, 0, 0, 0, 1, 6'h15); rd_chk("R7 load beats ack", 8'h0E);
        wr_reg(8'h0E, 32'h1234_56FF); rd_chk("R7 FF ack clears", 8'h0E);

        // R11 unmapped
        wr_reg(8'h10, 32'hFFFF_FFFF); rd_chk("R11 unmapped reads 0", 8'h10);
        rd_chk("R11 enable untouched", 8'h0D);

        // random mix against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [7:0]  ra;
            case ($urandom % 6)
                0: a = 8'h0C; 1: a = 8'h0D; 2: a = 8'h0E;
                3: a = 8'h0F; 4: a = 8'h10; default: a = 8'h20;
            endcase
            d = $urandom;
            if (a == 8'h0E && ($urandom % 2 == 0)) d[7:0] = 8'hFF;
            cyc(($urandom % 3) == 0, a, d, ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, 6'($urandom));
            ra = 8'h0C + 8'($urandom % 5);
            rd_chk("R2 R3 R4 R7 R11 random read", ra);
            check("R9 random irq", {31'b0, irq}, {31'b0, m_irq});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule